// File: doc/BRIEF.md
# Masked-write GPIO register bank

A 32-pin general purpose I/O peripheral on a simple memory-mapped register bus. The pins form two 16-pin banks. Each bank has its own output register and its own direction register. Every write carries a per-bit enable field in its upper half and data in its lower half. Software can therefore set or clear any group of pins in one bus write, with no read-modify-write.

Direction is active-low. A direction bit of 0 makes its pin drive the stored output bit. A direction bit of 1 releases the pin to high impedance, which is shown as a deasserted output enable. The pin levels pass through a two-flop synchronizer and can be read from a read-only input register. Reads are combinational from the address.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset, both direction registers read 0xFFFF, both output registers read 0x0000, `gpio_oe` is all zero and `gpio_o` is all zero.
- R2: The register offsets are input 0x000, low-bank output 0x100, high-bank output 0x104, low-bank direction 0x108 and high-bank direction 0x10C. Any other offset reads 0, and a write to it changes nothing.
- R3: A write to an output or direction register updates stored bit n with `bus_wdata[n]` only where `bus_wdata[n+16]` is 1. Stored bits whose enable is 0 keep their value.
- R4: The low-bank registers control pins 0 to 15. Bit n of a high-bank register controls pin n+16.
- R5: Reading an output or direction register returns its 16 stored bits in bits 15:0, with bits 31:16 reading 0.
- R6: `gpio_oe[p]` is 1 exactly when the direction bit of pin p is 0. `gpio_o[p]` equals the output bit of pin p while driving and 0 while released.
- R7: Reading the input register returns all 32 `gpio_i` levels in pin order. A level change becomes visible after exactly two rising clock edges.
- R8: A write to the input register changes no output or direction bit.
- R9: A write whose enable field `bus_wdata[31:16]` is zero changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Enable field in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| gpio_i | input | 32 | Pin levels in |
| gpio_o | output | 32 | Pin drive values |
| gpio_oe | output | 32 | Pin drive enable, 1 = driving |

## Verification
The bench builds the block with its default values: a bank width of 16 and two synchronizer stages. That setting covers the 16/16 split of the write word between the enable field and the data. It also makes the two-edge input latency visible at the input register, and it lets a single bank register hold a mix of driving and released pins. A behavioural model of the registers and the synchronizer is compared against the pins and the read data on every cycle. Directed and pseudo-random writes reach every offset, including unmapped ones and writes with a zero enable field.

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank #(
  parameter int BANK_W      = 16,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] IN_ADDR  = 'h000,
  parameter logic [ADDR_W-1:0] OUT_BASE = 'h100,
  parameter logic [ADDR_W-1:0] DIR_BASE = 'h108
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [2*BANK_W-1:0]   bus_wdata,
  output logic [2*BANK_W-1:0]   bus_rdata,
  input  logic [2*BANK_W-1:0]   gpio_i,
  output logic [2*BANK_W-1:0]   gpio_o,
  output logic [2*BANK_W-1:0]   gpio_oe
);
  localparam int PIN_W = 2 * BANK_W;
  localparam int NBANK = 2;

  logic [BANK_W-1:0] wr_mask, wr_data;
  logic [PIN_W-1:0]  out_all, dir_all;
  logic [PIN_W-1:0]  sync_q [SYNC_STAGES];

  assign wr_mask = bus_wdata[PIN_W-1:BANK_W];
  assign wr_data = bus_wdata[BANK_W-1:0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] OUT_A = OUT_BASE + ADDR_W'(4 * b);
    localparam logic [ADDR_W-1:0] DIR_A = DIR_BASE + ADDR_W'(4 * b);
    logic [BANK_W-1:0] out_q, dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q <= '0;
        dir_q <= '1;
      end else if (bus_we) begin
        if (bus_addr == OUT_A) out_q <= (out_q & ~wr_mask) | (wr_data & wr_mask);
        if (bus_addr == DIR_A) dir_q <= (dir_q & ~wr_mask) | (wr_data & wr_mask);
      end
    end

    assign out_all[b*BANK_W +: BANK_W] = out_q;
    assign dir_all[b*BANK_W +: BANK_W] = dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= gpio_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign gpio_oe = ~dir_all;
  assign gpio_o  = out_all & ~dir_all;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == IN_ADDR) bus_rdata = sync_q[SYNC_STAGES-1];
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == OUT_BASE + ADDR_W'(4 * b))
        bus_rdata = {{BANK_W{1'b0}}, out_all[b*BANK_W +: BANK_W]};
      if (bus_addr == DIR_BASE + ADDR_W'(4 * b))
        bus_rdata = {{BANK_W{1'b0}}, dir_all[b*BANK_W +: BANK_W]};
    end
  end
endmodule

// File: rtl/gpio_mask_bank_chk.sv
module gpio_mask_bank_chk #(
  parameter int BANK_W = 16,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] IN_ADDR  = 'h000,
  parameter logic [ADDR_W-1:0] OUT_BASE = 'h100
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [2*BANK_W-1:0] bus_wdata,
  input logic [2*BANK_W-1:0] gpio_o,
  input logic [2*BANK_W-1:0] gpio_oe,
  input logic [2*BANK_W-1:0] out_all,
  input logic [2*BANK_W-1:0] dir_all
);
  localparam int PIN_W = 2 * BANK_W;
  logic [BANK_W-1:0] msk, dat;
  assign msk = bus_wdata[PIN_W-1:BANK_W];
  assign dat = bus_wdata[BANK_W-1:0];

  assert_masked_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OUT_BASE) |=>
      ((out_all[BANK_W-1:0] & $past(msk)) == ($past(dat) & $past(msk))));

  assert_masked_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OUT_BASE) |=>
      ((out_all[BANK_W-1:0] & ~$past(msk)) == ($past(out_all[BANK_W-1:0]) & ~$past(msk))));

  assert_zero_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && msk == '0) |=> ($stable(out_all) && $stable(dir_all)));

  assert_input_wr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == IN_ADDR) |=> ($stable(out_all) && $stable(dir_all)));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(out_all) && $stable(dir_all)));

  assert_released_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_o & ~gpio_oe) == '0));
endmodule

bind gpio_mask_bank gpio_mask_bank_chk #(
  .BANK_W(BANK_W), .ADDR_W(ADDR_W), .IN_ADDR(IN_ADDR), .OUT_BASE(OUT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .gpio_o(gpio_o), .gpio_oe(gpio_oe),
  .out_all(out_all), .dir_all(dir_all)
);

// File: tb/gpio_mask_bank_tb.sv
module gpio_mask_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, gpio_i = '0;
  logic [31:0] bus_rdata, gpio_o, gpio_oe;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] m_out = 32'h0, m_dir = 32'hFFFF_FFFF, m_s1 = 0, m_s2 = 0;

  gpio_mask_bank u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] m_read(logic [11:0] a);
    case (a)
      12'h000: return m_s2;
      12'h100: return {16'h0, m_out[15:0]};
      12'h104: return {16'h0, m_out[31:16]};
      12'h108: return {16'h0, m_dir[15:0]};
      12'h10C: return {16'h0, m_dir[31:16]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [15:0] upd(logic [15:0] old, logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out <= 0; m_dir <= '1; m_s1 <= 0; m_s2 <= 0;
    end else begin
      m_s1 <= gpio_i; m_s2 <= m_s1;
      if (bus_we) case (bus_addr)
        12'h100: m_out[15:0]  <= upd(m_out[15:0], bus_wdata);
        12'h104: m_out[31:16] <= upd(m_out[31:16], bus_wdata);
        12'h108: m_dir[15:0]  <= upd(m_dir[15:0], bus_wdata);
        12'h10C: m_dir[31:16] <= upd(m_dir[31:16], bus_wdata);
        default: ;
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 per-cycle gpio_oe", gpio_oe, ~m_dir);
    chk("R6 per-cycle gpio_o", gpio_o, m_out & ~m_dir);
    chk("R5 per-cycle bus_rdata", bus_rdata, m_read(bus_addr));
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); #1;
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk); #1;
    bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2345;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset oe", gpio_oe, 32'h0);
    chk("R1 reset o", gpio_o, 32'h0);
    rd("R1 reset OUT lo", 12'h100, 32'h0);
    rd("R1 reset OUT hi", 12'h104, 32'h0);
    rd("R1 reset DIR lo", 12'h108, 32'h0000_FFFF);
    rd("R1 reset DIR hi", 12'h10C, 32'h0000_FFFF);

    wr(12'h100, 32'h00FF_A5A5);
    rd("R3 masked OUT lo", 12'h100, 32'h0000_00A5);
    wr(12'h100, 32'h0F00_FFFF);
    rd("R3 keep unenabled", 12'h100, 32'h0000_0FA5);
    wr(12'h108, 32'hFFFF_FF00);
    rd("R5 DIR lo readback", 12'h108, 32'h0000_FF00);
    #1 chk("R6 oe low byte", gpio_oe, 32'h0000_00FF);
    chk("R6 o low byte", gpio_o, 32'h0000_00A5);

    wr(12'h104, 32'h0000_FFFF);
    rd("R9 zero mask OUT hi", 12'h104, 32'h0);
    wr(12'h108, 32'h0000_0000);
    rd("R9 zero mask DIR lo", 12'h108, 32'h0000_FF00);

    wr(12'h104, 32'hFFFF_1234);
    wr(12'h10C, 32'h00FF_0000);
    rd("R4 OUT hi", 12'h104, 32'h0000_1234);
    #1 chk("R4 high bank oe", gpio_oe, 32'h00FF_00FF);
    chk("R4 high bank o", gpio_o, 32'h0034_00A5);

    wr(12'h000, 32'hFFFF_0000);
    rd("R8 input write OUT lo", 12'h100, 32'h0000_0FA5);
    rd("R8 input write DIR lo", 12'h108, 32'h0000_FF00);
    wr(12'h110, 32'hFFFF_FFFF);
    rd("R2 unmapped reads zero", 12'h110, 32'h0);
    rd("R2 unmapped write OUT hi", 12'h104, 32'h0000_1234);
    rd("R2 unmapped write DIR hi", 12'h10C, 32'h0000_FF00);

    @(negedge clk); #1;
    bus_addr = 12'h000; gpio_i = 32'hDEAD_BEEF;
    @(negedge clk); #2 chk("R7 not after one edge", bus_rdata, 32'h0);
    @(negedge clk); #2 chk("R7 visible after two edges", bus_rdata, 32'hDEAD_BEEF);
    gpio_i = 32'h1357_9BDF;
    @(negedge clk); @(negedge clk); #2 chk("R7 second pattern", bus_rdata, 32'h1357_9BDF);

    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[2:0])
        3'd0: a = 12'h000; 3'd1: a = 12'h100; 3'd2: a = 12'h104;
        3'd3: a = 12'h108; 3'd4: a = 12'h10C; 3'd5: a = 12'h10C;
        3'd6: a = 12'h100; default: a = 12'h0F0;
      endcase
      @(negedge clk); #1;
      gpio_i = {lfsr[15:0], lfsr[31:16]};
      bus_we = lfsr[5]; bus_addr = a;
      bus_wdata = lfsr[7] ? {16'h0, lfsr[31:16]} : {lfsr[23:8], lfsr[31:16]};
    end
    @(negedge clk); #1 bus_we = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule